// File: doc/BRIEF.md
# Random Number Generator Control Sequencer

This block is the register-level front end of a random number generator. A host reaches it through a plain 32-bit register bus with separate read and write strobes and a byte offset. Through this bus the host can identify the block, start two background jobs, mask completion interrupts, clear the interrupt line, reset the block from software and fetch random words. The two jobs are seeding and self-test. Each job moves from idle to running when the host starts it. It moves from running to done after a fixed, parameterised number of clock cycles, which its own counter measures.

The status word combines the phases of both jobs into busy, ready and done flags. It also carries fixed fields that describe a full five-word output buffer and a seed that is always available. The data register is served by a 32-bit maximal-length LFSR that stands in for a real entropy source. Each read of the data register steps the LFSR and returns the new value. When seeding finishes, the LFSR is reloaded from a mix of a constant and a free-running cycle count. A single level interrupt goes high when either job completes, unless the done mask is set. It stays high until a clear command arrives or the block sees a hardware reset.

Top module: `rngc_top`

## Requirements
- R1: A read at offset 0x00 returns 0x10000240. This value holds type 1 in bits 31:28, major revision 0x02 in bits 15:8 and minor revision 0x40 in bits 7:0.
- R2: A read at any offset other than 0x00, 0x04, 0x08, 0x0C and 0x14 returns zero. This includes 0x10 and 0x18.
- R3: A write at offset 0x08 replaces the error-mask bit 6, the done-mask bit 5 and the auto-seed bit 4. Reading offset 0x08 returns exactly those three bits, and every other bit reads 0.
- R4: Writing offset 0x04 with bit 1 set starts seeding, and writing it with bit 0 set starts the self-test. While a job runs, a read of offset 0x04 returns bit 1 for seeding and bit 0 for the self-test. All other bits of that read are 0.
- R5: A job started at clock edge E finishes at edge E+N, where N is SEED_CYCLES for seeding or ST_CYCLES for the self-test. From then on, status bit 5 (seed done) or status bit 4 (self-test done) is set, and the job's running bit reads 0.
- R6: Status bit 1 (busy) is 1 while either job runs. Status bit 0 (ready) is its complement.
- R7: Status bits 15:12 and 11:8 each read 5. Bit 6 reads 1. Bits 7, 3 and 2 and bits 31:16 read 0.
- R8: When a job finishes, irq goes high on the same edge unless the done-mask bit is 1. Once high, irq stays high until it is cleared.
- R9: A write at offset 0x04 with bit 4 (clear interrupt) or bit 5 (clear error) set lowers irq on the next edge.
- R10: A write at offset 0x04 with bit 6 set returns both jobs to idle and clears the three control bits. Any start bits in the same write then take effect in that same cycle.
- R11: A read at offset 0x14 advances the LFSR and returns its new value. The LFSR starts at 0x00000001 after reset. Its step is next = {s[30:0], s[31]^s[21]^s[1]^s[0]}. A data read never returns zero.
- R12: When seeding finishes, the LFSR is reloaded with a nonzero value. Later reads continue the step rule from that value.
- R13: A read returns its value on bus_rdata on the clock edge that samples bus_rd. The value then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level completion interrupt |

## Verification
The bound checker checks the following on every cycle:
- An interrupt only rises when a job is in its done phase, and a masked completion never raises it.
- A clear command lowers the interrupt.
- A running job never falls back to idle without a software reset.
- Control writes land as written.
- Read data holds between reads.
- Data reads are never zero.

Some behaviour only the bench's scenarios can show:
- The exact cycle on which each job finishes.
- The fixed status and version encodings.
- The zero returned for unmapped offsets.
- The exact LFSR sequence.
- How a software reset combines with start bits in one write.
- Whether seeding reloads the generator and the sequence then continues.

// File: rtl/rngc_pkg.sv
package rngc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } op_phase_t;

    typedef struct packed {
        logic mask_err;
        logic mask_done;
        logic auto_seed;
    } ctrl_t;

    localparam int unsigned OFS_VERSION = 32'h00;
    localparam int unsigned OFS_CMD     = 32'h04;
    localparam int unsigned OFS_CTRL    = 32'h08;
    localparam int unsigned OFS_STATUS  = 32'h0C;
    localparam int unsigned OFS_DATA    = 32'h14;

    // command bit positions
    localparam int unsigned CB_SELFTEST = 0;
    localparam int unsigned CB_SEED     = 1;
    localparam int unsigned CB_CLRINT   = 4;
    localparam int unsigned CB_CLRERR   = 5;
    localparam int unsigned CB_SWRST    = 6;

    // control bit positions
    localparam int unsigned KB_AUTOSEED = 4;
    localparam int unsigned KB_MASKDONE = 5;
    localparam int unsigned KB_MASKERR  = 6;

    localparam logic [3:0] BUF_DEPTH  = 4'd5;
    localparam logic [3:0] TYPE_CODE  = 4'd1;
    localparam logic [7:0] REV_MAJOR  = 8'h02;
    localparam logic [7:0] REV_MINOR  = 8'h40;

    // job index: matches the start bit in the command word
    localparam int unsigned JOB_SELFTEST = 0;
    localparam int unsigned JOB_SEED     = 1;
    localparam int unsigned NUM_JOBS     = 2;

    function automatic logic [31:0] version_word();
        logic [31:0] v;
        v = '0;
        v[31:28] = TYPE_CODE;
        v[15:8]  = REV_MAJOR;
        v[7:0]   = REV_MINOR;
        return v;
    endfunction

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [31:0] status_word(input op_phase_t st,
                                                input op_phase_t sd);
        logic [31:0] w;
        logic        busy;
        busy     = (st == PH_RUN) || (sd == PH_RUN);
        w        = '0;
        w[15:12] = BUF_DEPTH;
        w[11:8]  = BUF_DEPTH;
        w[6]     = 1'b1;
        w[5]     = (sd == PH_DONE);
        w[4]     = (st == PH_DONE);
        w[1]     = busy;
        w[0]     = !busy;
        return w;
    endfunction

    function automatic logic [31:0] ctrl_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[KB_MASKERR]  = c.mask_err;
        w[KB_MASKDONE] = c.mask_done;
        w[KB_AUTOSEED] = c.auto_seed;
        return w;
    endfunction

endpackage

// File: rtl/rngc_op_seq.sv
module rngc_op_seq
    import rngc_pkg::*;
#(
    parameter int unsigned CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sreset,
    input  logic      start,
    output op_phase_t phase,
    output logic      finish
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic [CW-1:0] remain;

    always_comb begin
        finish = (phase == PH_RUN) && (remain == '0) && !sreset && !start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            remain <= '0;
        end else if (start) begin
            phase  <= PH_RUN;
            remain <= LOAD;
        end else if (sreset) begin
            phase  <= PH_IDLE;
            remain <= '0;
        end else if (phase == PH_RUN) begin
            if (remain == '0) begin
                phase <= PH_DONE;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

endmodule

// File: rtl/rngc_lfsr.sv
module rngc_lfsr
    import rngc_pkg::*;
#(
    parameter logic [31:0] INIT = 32'h0000_0001,
    parameter logic [31:0] MIX  = 32'h9E37_79B9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        advance,
    input  logic        reseed,
    output logic [31:0] word_next
);
    logic [31:0] state;
    logic [31:0] tick;
    logic [31:0] fresh;

    always_comb begin
        word_next = lfsr_step(state);
        fresh     = MIX ^ tick;
        if (fresh == '0) begin
            fresh = INIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= INIT;
            tick  <= '0;
        end else begin
            tick <= tick + 1'b1;
            if (reseed) begin
                state <= fresh;
            end else if (advance) begin
                state <= word_next;
            end
        end
    end

endmodule

// File: rtl/rngc_irq.sv
module rngc_irq (
    input  logic clk,
    input  logic rst,
    input  logic done_any,
    input  logic mask_done,
    input  logic clear,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (done_any && !mask_done) begin
            irq <= 1'b1;
        end else if (clear) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/rngc_top.sv
module rngc_top
    import rngc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned ST_CYCLES   = 16,
    parameter int unsigned SEED_CYCLES = 32,
    parameter logic [31:0] LFSR_INIT   = 32'h0000_0001,
    parameter logic [31:0] LFSR_MIX    = 32'h9E37_79B9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int unsigned JOB_CYC [NUM_JOBS] = '{ST_CYCLES, SEED_CYCLES};

    logic          cmd_wr, ctrl_wr, data_rd;
    logic          sreset, clear_req;
    ctrl_t         ctrl_q;
    op_phase_t     phase   [NUM_JOBS];
    logic [NUM_JOBS-1:0] job_start, job_finish;
    logic [31:0]   lfsr_word;
    logic [31:0]   rd_mux;
    logic [31:0]   cmd_live;

    always_comb begin
        cmd_wr    = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
        ctrl_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        data_rd   = bus_rd && (bus_addr == ADDR_W'(OFS_DATA));
        sreset    = cmd_wr && bus_wdata[CB_SWRST];
        clear_req = cmd_wr && (bus_wdata[CB_CLRINT] || bus_wdata[CB_CLRERR]);
    end

    for (genvar g = 0; g < NUM_JOBS; g++) begin : g_job
        assign job_start[g] = cmd_wr && bus_wdata[g];
        rngc_op_seq #(.CYCLES(JOB_CYC[g])) u_seq (
            .clk    (clk),
            .rst    (rst),
            .sreset (sreset),
            .start  (job_start[g]),
            .phase  (phase[g]),
            .finish (job_finish[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || sreset) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.mask_err  <= bus_wdata[KB_MASKERR];
            ctrl_q.mask_done <= bus_wdata[KB_MASKDONE];
            ctrl_q.auto_seed <= bus_wdata[KB_AUTOSEED];
        end
    end

    rngc_lfsr #(.INIT(LFSR_INIT), .MIX(LFSR_MIX)) u_lfsr (
        .clk       (clk),
        .rst       (rst),
        .advance   (data_rd),
        .reseed    (job_finish[JOB_SEED]),
        .word_next (lfsr_word)
    );

    rngc_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .done_any  (|job_finish),
        .mask_done (ctrl_q.mask_done),
        .clear     (clear_req),
        .irq       (irq)
    );

    always_comb begin
        cmd_live = '0;
        cmd_live[CB_SEED]     = (phase[JOB_SEED] == PH_RUN);
        cmd_live[CB_SELFTEST] = (phase[JOB_SELFTEST] == PH_RUN);
        case (bus_addr)
            ADDR_W'(OFS_VERSION): rd_mux = version_word();
            ADDR_W'(OFS_CMD):     rd_mux = cmd_live;
            ADDR_W'(OFS_CTRL):    rd_mux = ctrl_word(ctrl_q);
            ADDR_W'(OFS_STATUS):  rd_mux = status_word(phase[JOB_SELFTEST], phase[JOB_SEED]);
            ADDR_W'(OFS_DATA):    rd_mux = lfsr_word;
            default:              rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/rngc_chk.sv
module rngc_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic [1:0]        st_phase,
    input logic [1:0]        sd_phase,
    input logic [1:0]        fin,
    input logic              mask_done,
    input logic [2:0]        ctrl_bits
);
    logic cmd_w, ctrl_w, data_r, srst;
    assign cmd_w  = bus_wr && (bus_addr == ADDR_W'(32'h04));
    assign ctrl_w = bus_wr && (bus_addr == ADDR_W'(32'h08));
    assign data_r = bus_rd && (bus_addr == ADDR_W'(32'h14));
    assign srst   = cmd_w && bus_wdata[6];

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (st_phase == 2'd2 || sd_phase == 2'd2));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (|fin && mask_done && !irq) |=> !irq);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_w && |bus_wdata[5:4] && !(|fin)) |=> !irq);

    // R5
    seed_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (sd_phase == 2'd1 && !srst) |=> sd_phase != 2'd0);

    // R5
    st_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (st_phase == 2'd1 && !srst) |=> st_phase != 2'd0);

    // R3
    ctrl_land_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_w |=> ctrl_bits == {$past(bus_wdata[6]), $past(bus_wdata[5]), $past(bus_wdata[4])});

    // R11
    data_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        data_r |=> bus_rdata != 32'h0);

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind rngc_top rngc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .st_phase  (phase[0]),
    .sd_phase  (phase[1]),
    .fin       (job_finish),
    .mask_done (ctrl_q.mask_done),
    .ctrl_bits ({ctrl_q.mask_err, ctrl_q.mask_done, ctrl_q.auto_seed})
);

// File: tb/sim_rngc_top.sv
module sim_rngc_top;
    localparam int unsigned AW   = 12;
    localparam int unsigned STC  = 16;
    localparam int unsigned SDC  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          done_flag = 0;

    logic [31:0] exp_q [$];
    bit          cmp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;
    logic [31:0] last_data = '0;

    always #2 clk = ~clk;

    rngc_top #(.ADDR_W(AW), .ST_CYCLES(STC), .SEED_CYCLES(SDC)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // monitor: compares each read result against the scoreboard
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            bit          c;
            string       t;
            e = exp_q.pop_front();
            c = cmp_q.pop_front();
            t = tag_q.pop_front();
            last_data = bus_rdata;
            if (c) begin
                checks++;
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: read got %08h expected %08h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e,
                      input bit c, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); cmp_q.push_back(c); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", t, act, e);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] m;
        logic [31:0] held;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // reset state
        chk({31'b0, irq}, 32'h0, "R8 reset irq");
        rd(12'h00, 32'h1000_0240, 1, "R1 version");
        rd(12'h04, 32'h0, 1, "R4 cmd idle");
        rd(12'h08, 32'h0, 1, "R3 ctrl reset");
        rd(12'h0C, 32'h0000_5541, 1, "R7 R6 status idle");

        // LFSR sequence from reset
        m = 32'h1;
        for (int i = 0; i < 6; i++) begin
            m = step(m);
            rd(12'h14, m, 1, "R11 lfsr step");
        end

        // R13 hold
        @(negedge clk);
        held = bus_rdata;
        repeat (3) @(negedge clk);
        chk(bus_rdata, held, "R13 rdata hold");

        // R2 unmapped
        rd(12'h10, 32'h0, 1, "R2 offset 0x10");
        rd(12'h18, 32'h0, 1, "R2 offset 0x18");
        rd(12'h0FC, 32'h0, 1, "R2 offset 0xFC");

        // R3 control
        wr(12'h08, 32'h70);
        rd(12'h08, 32'h70, 1, "R3 ctrl all");
        wr(12'h08, 32'hFFFF_FFFF);
        rd(12'h08, 32'h70, 1, "R3 ctrl other bits");
        wr(12'h08, 32'h20);
        rd(12'h08, 32'h20, 1, "R3 ctrl done mask");

        // masked self-test
        wr(12'h04, 32'h01);
        rd(12'h04, 32'h1, 1, "R4 selftest running");
        rd(12'h0C, 32'h0000_5542, 1, "R6 busy");
        repeat (STC + 4) @(negedge clk);
        chk({31'b0, irq}, 32'h0, "R8 masked no irq");
        rd(12'h0C, 32'h0000_5551, 1, "R5 selftest done");
        rd(12'h04, 32'h0, 1, "R5 selftest not running");

        // unmasked seed with exact timing
        wr(12'h08, 32'h00);
        wr(12'h04, 32'h02);
        repeat (SDC - 1) @(negedge clk);
        chk({31'b0, irq}, 32'h0, "R5 seed still running");
        @(negedge clk);
        chk({31'b0, irq}, 32'h1, "R8 irq at seed finish");
        rd(12'h0C, 32'h0000_5571, 1, "R5 seed done");
        rd(12'h04, 32'h0, 1, "R5 seed not running");
        chk({31'b0, irq}, 32'h1, "R8 irq held");

        // R12 reseed then continuation
        rd(12'h14, 32'h0, 0, "R12 reseed read");
        @(negedge clk);
        chk({31'b0, (last_data != 32'h0)}, 32'h1, "R12 reseed nonzero");
        chk({31'b0, (last_data != step(m))}, 32'h1, "R12 reseed changes sequence");
        m = last_data;
        m = step(m);
        rd(12'h14, m, 1, "R12 continue");

        // R9 clear-interrupt
        wr(12'h04, 32'h10);
        chk({31'b0, irq}, 32'h0, "R9 clear int");
        // R9 clear-error
        wr(12'h04, 32'h01);
        repeat (STC) @(negedge clk);
        chk({31'b0, irq}, 32'h1, "R8 irq at selftest finish");
        wr(12'h04, 32'h20);
        chk({31'b0, irq}, 32'h0, "R9 clear err");

        // both jobs together
        wr(12'h04, 32'h03);
        rd(12'h04, 32'h3, 1, "R4 both running");
        rd(12'h0C, 32'h0000_5542, 1, "R6 both busy");
        repeat (SDC + 4) @(negedge clk);
        rd(12'h0C, 32'h0000_5571, 1, "R6 R7 both done ready");
        wr(12'h04, 32'h10);

        // R10 software reset
        wr(12'h08, 32'h70);
        wr(12'h04, 32'h40);
        rd(12'h08, 32'h0, 1, "R10 ctrl cleared");
        rd(12'h04, 32'h0, 1, "R10 cmd idle");
        rd(12'h0C, 32'h0000_5541, 1, "R10 status idle");

        // R10 reset together with start
        wr(12'h08, 32'h70);
        wr(12'h04, 32'h42);
        rd(12'h08, 32'h0, 1, "R10 ctrl cleared with start");
        rd(12'h04, 32'h2, 1, "R10 start after reset");
        rd(12'h0C, 32'h0000_5542, 1, "R10 busy after reset start");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule